// File: doc/BRIEF.md
# Scan-Load Fault Emulation Controller

This controller runs a transient-fault campaign against a circuit whose every flip-flop sits on one serial scan chain. It first performs a fault-free reference pass of the whole test sequence from a reset state. It then shifts the final state of that pass out of the chain and keeps it in an internal register. After that it works through a list of fault records held in an external memory. Each record carries a start cycle and a complete circuit state in which any number of bits have already been inverted. The controller shifts that state into the chain with the circuit clock enable held low, then applies the test sequence from the start cycle onwards.

While a fault runs, the circuit outputs are checked one cycle after each vector against a table of expected outputs. The first disagreement halts the run at once and the fault is graded a failure. A run that reaches the end of the sequence cleanly is graded when its final state is shifted out and compared bit by bit with the stored reference state. A differing state means the fault is latent; an identical state means it is silent. One grade is reported per record, and a completion flag rises after the last record.

Top module: `scanload_fault_ctrl`

## Requirements
- R1: After reset, busy, done, res_valid, cut_rst, cut_en, scan_en and rec_rd are all low.
- R2: A start pulse gives exactly one cut_rst cycle. That is followed directly by TB_CYCLES cycles with cut_en high and vec_idx counting 0, 1, ... TB_CYCLES-1, before any record is read.
- R3: The final reference state is captured by STATE_W cycles of scan_en. Every fault spends STATE_W scan_en cycles loading its state. Every fault not graded a failure spends another STATE_W scan_en cycles on the final compare. There are no other scan_en cycles.
- R4: Records are read in address order 0 .. num_faults-1, one rec_rd pulse each, with data due one cycle after rec_rd. A record is {start cycle in the upper CYC_W bits, state in the lower STATE_W bits}. The state goes out on scan_in most significant bit first, and the chain's last bit appears on scan_out.
- R5: A fault run with start cycle s below TB_CYCLES drives cut_en with vec_idx starting at s and rising by one per cycle.
- R6: cut_out after vector k is compared with exp_out while exp_idx equals k, one cycle later. On the first difference, cut_en stays low from that cycle on and the fault is graded failure (res_class 2'b01). The number of vectors applied is then k-s+1.
- R7: A fault that reaches the end without a difference applies TB_CYCLES-s vectors. It is graded latent (2'b10) if its scanned-out final state differs from the reference in any bit, and silent (2'b11) otherwise.
- R8: A loaded state may differ from the reference in several bits at once, and its grade follows the combined effect.
- R9: A start cycle at or beyond TB_CYCLES applies no vectors. It goes straight to the final-state compare.
- R10: Each record yields exactly one single-cycle res_valid pulse, with res_idx equal to its address.
- R11: done rises after the last grade and stays high until the next start. With num_faults zero, done follows the reference pass and no record is read.
- R12: cut_en and scan_en are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a campaign when idle or done |
| num_faults | input | FAULT_AW+1 | Number of records to process |
| rec_rd | output | 1 | Record memory read strobe |
| rec_addr | output | FAULT_AW | Record memory address |
| rec_rdata | input | CYC_W+STATE_W | Record data, one cycle after rec_rd |
| cut_rst | output | 1 | Synchronous reset to the circuit under evaluation |
| cut_en | output | 1 | Functional clock enable of the circuit |
| scan_en | output | 1 | Scan shift enable of the circuit |
| scan_in | output | 1 | Serial data into the chain |
| scan_out | input | 1 | Serial data from the end of the chain |
| vec_idx | output | CYC_W | Index of the stimulus vector being applied |
| cut_out | input | OUT_W | Circuit outputs |
| exp_idx | output | CYC_W | Index of the expected-output entry under comparison |
| exp_out | input | OUT_W | Expected outputs for exp_idx |
| res_valid | output | 1 | Grade valid pulse |
| res_idx | output | FAULT_AW | Record address of the grade |
| res_class | output | 2 | 01 failure, 10 latent, 11 silent |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | Campaign finished |

## Verification
The checks assume a few things about the environment. start arrives only while the controller is idle or done. num_faults stays stable during a campaign. Record data appears exactly one cycle after rec_rd, and exp_out follows exp_idx combinationally. Start cycles are also assumed to fit the counter width. The bench honours all of this. Its record memory is a registered read, its expected table is a plain indexed array, and it pulses start only after done. Its circuit model shifts on scan_en and steps on cut_en and never does both. Fault grades are predicted by an independent model of that circuit, run from the faulty state to the end of the sequence.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'b00,
        CLS_FAIL   = 2'b01,
        CLS_LATENT = 2'b10,
        CLS_SILENT = 2'b11
    } fe_class_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GRST,
        S_GRUN,
        S_GCAP,
        S_FETCH,
        S_LOAD,
        S_SHIN,
        S_RUN,
        S_DRAIN,
        S_SCMP,
        S_REPORT,
        S_DONE
    } fe_state_e;

endpackage

// File: rtl/fe_bit_counter.sv
module fe_bit_counter #(
    parameter int COUNT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] TOP = CW'(COUNT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP); // R3

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && last) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/fe_golden_store.sv
module fe_golden_store #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic compare,
    input  logic clr_diff,
    input  logic scan_bit,
    output logic diff
);
    typedef struct packed {
        logic [W-1:0] gold;
        logic         diff;
    } gs_t;

    gs_t r_q, r_d;

    assign diff = r_q.diff;

    always_comb begin
        r_d = r_q;
        if (clr_diff) r_d.diff = 1'b0;
        if (capture) begin
            r_d.gold = {r_q.gold[W-2:0], scan_bit};
        end else if (compare) begin
            r_d.gold = {r_q.gold[W-2:0], r_q.gold[W-1]};
            if (scan_bit != r_q.gold[W-1]) r_d.diff = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_CAP_CMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture && compare)); // R7

    AST_DIFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (diff && !clr_diff) |=> diff); // R7

endmodule

// File: rtl/fe_out_checker.sv
module fe_out_checker #(
    parameter int OUT_W = 4,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [CYC_W-1:0] issue_idx,
    input  logic [OUT_W-1:0] cut_out,
    input  logic [OUT_W-1:0] exp_out,
    output logic [CYC_W-1:0] exp_idx,
    output logic             mismatch
);
    typedef struct packed {
        logic             vld;
        logic [CYC_W-1:0] idx;
    } ck_t;

    ck_t r_q, r_d;

    assign exp_idx  = r_q.idx;
    assign mismatch = r_q.vld && (cut_out != exp_out);

    always_comb begin
        r_d     = r_q;
        r_d.vld = issue;
        if (issue) r_d.idx = issue_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_MISMATCH_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> $past(issue)); // R6

endmodule

// File: rtl/scanload_fault_ctrl.sv
module scanload_fault_ctrl
    import fe_pkg::*;
#(
    parameter int STATE_W   = 16,
    parameter int OUT_W     = 4,
    parameter int CYC_W     = 8,
    parameter int TB_CYCLES = 20,
    parameter int FAULT_AW  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [FAULT_AW:0]        num_faults,
    output logic                     rec_rd,
    output logic [FAULT_AW-1:0]      rec_addr,
    input  logic [CYC_W+STATE_W-1:0] rec_rdata,
    output logic                     cut_rst,
    output logic                     cut_en,
    output logic                     scan_en,
    output logic                     scan_in,
    input  logic                     scan_out,
    output logic [CYC_W-1:0]         vec_idx,
    input  logic [OUT_W-1:0]         cut_out,
    output logic [CYC_W-1:0]         exp_idx,
    input  logic [OUT_W-1:0]         exp_out,
    output logic                     res_valid,
    output logic [FAULT_AW-1:0]      res_idx,
    output logic [1:0]               res_class,
    output logic                     busy,
    output logic                     done
);
    localparam int REC_W = CYC_W + STATE_W;
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(TB_CYCLES - 1);

    typedef struct packed {
        fe_state_e           st;
        logic [CYC_W-1:0]    cyc;
        logic [FAULT_AW-1:0] fidx;
        logic [STATE_W-1:0]  ld;
        logic                fail;
    } ctl_t;

    ctl_t r_q, r_d;

    logic cnt_clr, cnt_step, cnt_last;
    logic g_cap, g_cmp, g_clr, g_diff;
    logic chk_issue, mismatch;
    fe_class_e cls;

    fe_bit_counter #(.COUNT(STATE_W)) u_bitcnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .step (cnt_step),
        .last (cnt_last)
    );

    fe_golden_store #(.W(STATE_W)) u_gold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (g_cap),
        .compare (g_cmp),
        .clr_diff(g_clr),
        .scan_bit(scan_out),
        .diff    (g_diff)
    );

    fe_out_checker #(.OUT_W(OUT_W), .CYC_W(CYC_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (chk_issue),
        .issue_idx(r_q.cyc),
        .cut_out  (cut_out),
        .exp_out  (exp_out),
        .exp_idx  (exp_idx),
        .mismatch (mismatch)
    );

    assign vec_idx   = r_q.cyc;
    assign rec_addr  = r_q.fidx;
    assign res_idx   = r_q.fidx;
    assign res_class = cls;

    always_comb begin
        r_d       = r_q;
        cut_rst   = 1'b0;
        cut_en    = 1'b0;
        scan_en   = 1'b0;
        scan_in   = 1'b0;
        rec_rd    = 1'b0;
        res_valid = 1'b0;
        cls       = CLS_NONE;
        cnt_clr   = 1'b0;
        cnt_step  = 1'b0;
        g_cap     = 1'b0;
        g_cmp     = 1'b0;
        g_clr     = 1'b0;
        chk_issue = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;

        case (r_q.st)
            S_IDLE: begin
                busy = 1'b0;
                if (start) r_d.st = S_GRST;
            end
            S_GRST: begin
                cut_rst = 1'b1;
                r_d.cyc = '0;
                r_d.st  = S_GRUN;
            end
            S_GRUN: begin
                cut_en = 1'b1;
                if (r_q.cyc == LAST_CYC) begin
                    cnt_clr = 1'b1;
                    r_d.st  = S_GCAP;
                end else begin
                    r_d.cyc = r_q.cyc + 1'b1;
                end
            end
            S_GCAP: begin
                scan_en  = 1'b1;
                g_cap    = 1'b1;
                cnt_step = 1'b1;
                if (cnt_last) begin
                    r_d.fidx = '0;
                    r_d.st   = (num_faults == '0) ? S_DONE : S_FETCH;
                end
            end
            S_FETCH: begin
                rec_rd = 1'b1;
                r_d.st = S_LOAD;
            end
            S_LOAD: begin
                r_d.ld   = rec_rdata[STATE_W-1:0];
                r_d.cyc  = rec_rdata[REC_W-1:STATE_W];
                r_d.fail = 1'b0;
                cnt_clr  = 1'b1;
                g_clr    = 1'b1;
                r_d.st   = S_SHIN;
            end
            S_SHIN: begin
                scan_en  = 1'b1;
                scan_in  = r_q.ld[STATE_W-1];
                r_d.ld   = {r_q.ld[STATE_W-2:0], 1'b0};
                cnt_step = 1'b1;
                if (cnt_last) begin
                    r_d.st = (r_q.cyc > LAST_CYC) ? S_SCMP : S_RUN;
                end
            end
            S_RUN: begin
                if (mismatch) begin
                    r_d.fail = 1'b1;
                    r_d.st   = S_REPORT;
                end else begin
                    cut_en    = 1'b1;
                    chk_issue = 1'b1;
                    if (r_q.cyc == LAST_CYC) r_d.st = S_DRAIN;
                    else                     r_d.cyc = r_q.cyc + 1'b1;
                end
            end
            S_DRAIN: begin
                if (mismatch) begin
                    r_d.fail = 1'b1;
                    r_d.st   = S_REPORT;
                end else begin
                    r_d.st = S_SCMP;
                end
            end
            S_SCMP: begin
                scan_en  = 1'b1;
                g_cmp    = 1'b1;
                cnt_step = 1'b1;
                if (cnt_last) r_d.st = S_REPORT;
            end
            S_REPORT: begin
                res_valid = 1'b1;
                if (r_q.fail)    cls = CLS_FAIL;
                else if (g_diff) cls = CLS_LATENT;
                else             cls = CLS_SILENT;
                if (({1'b0, r_q.fidx} + 1'b1) == num_faults) begin
                    r_d.st = S_DONE;
                end else begin
                    r_d.fidx = r_q.fidx + 1'b1;
                    r_d.st   = S_FETCH;
                end
            end
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
                if (start) r_d.st = S_GRST;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cut_en && scan_en)); // R12

    AST_RST_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cut_rst |=> (cut_en && vec_idx == '0)); // R2

    AST_FAIL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class == CLS_FAIL) |-> !$past(cut_en)); // R6

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R10

    AST_CLASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_class != CLS_NONE)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cut_en && !scan_en && !rec_rd)); // R11

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cut_en |-> (vec_idx <= LAST_CYC)); // R5

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rd |=> !rec_rd); // R4

endmodule

// File: tb/scanload_fault_ctrl_bench.sv
module scanload_fault_ctrl_bench;
    localparam int F  = 16;
    localparam int OW = 4;
    localparam int CW = 8;
    localparam int C  = 20;
    localparam int AW = 4;
    localparam int NREC = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW:0] num_faults = '0;
    logic rec_rd;
    logic [AW-1:0] rec_addr;
    logic [CW+F-1:0] rec_rdata;
    logic cut_rst, cut_en, scan_en, scan_in, scan_out;
    logic [CW-1:0] vec_idx, exp_idx;
    logic [OW-1:0] cut_out, exp_out;
    logic res_valid, busy, done;
    logic [AW-1:0] res_idx;
    logic [1:0] res_class;

    always #4 clk = ~clk;

    scanload_fault_ctrl #(.STATE_W(F), .OUT_W(OW), .CYC_W(CW), .TB_CYCLES(C), .FAULT_AW(AW))
    u_scanload_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .num_faults(num_faults),
        .rec_rd(rec_rd), .rec_addr(rec_addr), .rec_rdata(rec_rdata),
        .cut_rst(cut_rst), .cut_en(cut_en), .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(scan_out), .vec_idx(vec_idx), .cut_out(cut_out),
        .exp_idx(exp_idx), .exp_out(exp_out), .res_valid(res_valid),
        .res_idx(res_idx), .res_class(res_class), .busy(busy), .done(done)
    );

    // behavioural circuit: shift chain, bits 0 and 8 reloaded from stimulus
    function automatic logic [1:0] stim(int k);
        return 2'((k * 3 + 1) % 4);
    endfunction
    function automatic logic [F-1:0] step_state(logic [F-1:0] s, int k);
        logic [F-1:0] n;
        logic [1:0] v;
        v = stim(k);
        n = {s[F-2:0], v[0]};
        n[8] = v[1];
        return n;
    endfunction
    function automatic logic [OW-1:0] outs(logic [F-1:0] s);
        return s[F-1:F-OW];
    endfunction

    logic [F-1:0] cut_st;
    always @(posedge clk) begin
        if (cut_rst)      cut_st <= '0;
        else if (scan_en) cut_st <= {cut_st[F-2:0], scan_in};
        else if (cut_en)  cut_st <= step_state(cut_st, int'(vec_idx));
    end
    assign scan_out = cut_st[F-1];
    assign cut_out  = outs(cut_st);

    // reference pass and tables
    logic [F-1:0] gs [C+1];
    logic [OW-1:0] exp_mem [C];
    logic [CW+F-1:0] rec_mem [NREC];
    assign exp_out = (int'(exp_idx) < C) ? exp_mem[exp_idx] : '0;

    always @(posedge clk) if (rec_rd) rec_rdata <= rec_mem[rec_addr];

    int n_chk = 0, n_bad = 0, wd = 0;

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor
    logic mon_on = 1'b0, in_fault = 1'b0;
    int g_en, f_en, f_first, rd_cnt, rst_cnt, scan_cnt, excl_bad, order_bad, res_n;
    int r_cls [NREC];
    int r_idx [NREC];
    int r_en [NREC];
    int r_first [NREC];

    always @(negedge clk) if (mon_on) begin
        if (cut_rst) rst_cnt++;
        if (rec_rd) begin rd_cnt++; in_fault = 1'b1; end
        if (scan_en) scan_cnt++;
        if (cut_en && scan_en) excl_bad++;
        if (cut_en) begin
            if (!in_fault) begin
                if (int'(vec_idx) != g_en) order_bad++;
                g_en++;
            end else begin
                if (f_en == 0) f_first = int'(vec_idx);
                f_en++;
            end
        end
        if (res_valid && res_n < NREC) begin
            r_cls[res_n] = int'(res_class);
            r_idx[res_n] = int'(res_idx);
            r_en[res_n] = f_en;
            r_first[res_n] = f_first;
            res_n++;
            f_en = 0;
            f_first = -1;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // expected grade: 1 failure, 2 latent, 3 silent
    task automatic predict(input int inj, input logic [F-1:0] mask,
                           output int cls, output int napp);
        logic [F-1:0] s;
        cls = 0;
        napp = 0;
        s = gs[(inj < C) ? inj : C] ^ mask;
        for (int k = inj; k < C; k++) begin
            s = step_state(s, k);
            napp++;
            if (outs(s) != exp_mem[k]) begin
                cls = 1;
                break;
            end
        end
        if (cls == 0) cls = (s != gs[C]) ? 2 : 3;
    endtask

    int t_inj [NREC];
    logic [F-1:0] t_mask [NREC];

    task automatic set_rec(input int i, input int inj, input logic [F-1:0] mask);
        t_inj[i] = inj;
        t_mask[i] = mask;
        rec_mem[i] = {CW'(inj), gs[(inj < C) ? inj : C] ^ mask};
    endtask

    task automatic run_campaign(input int n, input string name);
        int ecls, enap, nonfail;
        @(posedge clk);
        g_en = 0; f_en = 0; f_first = -1; rd_cnt = 0; rst_cnt = 0;
        scan_cnt = 0; excl_bad = 0; order_bad = 0; res_n = 0;
        in_fault = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
        num_faults = (AW+1)'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && busy, "R11 done drops on start", int'(done), 0);
        for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
        check(done == 1'b1, "R11 done after last record", int'(done), 1);
        repeat (3) @(negedge clk);
        check(done && !busy, "R11 done held", int'(done), 1);
        mon_on = 1'b0;
        $display("campaign %s: %0d grades", name, res_n);
        check(rst_cnt == 1, "R2 single cut_rst", rst_cnt, 1);
        check(g_en == C && order_bad == 0, "R2 reference vectors in order", g_en, C);
        check(rd_cnt == n, "R4 one read per record", rd_cnt, n);
        check(res_n == n, "R10 one grade per record", res_n, n);
        check(excl_bad == 0, "R12 cut_en with scan_en", excl_bad, 0);
        nonfail = 0;
        for (int i = 0; i < n && i < res_n; i++) begin
            predict(t_inj[i], t_mask[i], ecls, enap);
            if (ecls != 1) nonfail++;
            check(r_idx[i] == i, "R10 res_idx order", r_idx[i], i);
            if (ecls == 1)
                check(r_cls[i] == ecls, "R6 failure grade", r_cls[i], ecls);
            else
                check(r_cls[i] == ecls, "R7 latent/silent grade", r_cls[i], ecls);
            if ($countones(t_mask[i]) > 1)
                check(r_cls[i] == ecls, "R8 multi-bit fault grade", r_cls[i], ecls);
            if (t_inj[i] >= C)
                check(r_en[i] == 0, "R9 no vectors past end", r_en[i], 0);
            else if (ecls == 1)
                check(r_en[i] == enap, "R6 vectors before halt", r_en[i], enap);
            else
                check(r_en[i] == enap, "R7 vectors to end", r_en[i], enap);
            if (enap > 0 && t_inj[i] < C)
                check(r_first[i] == t_inj[i], "R5 run starts at injection cycle", r_first[i], t_inj[i]);
        end
        check(scan_cnt == F * (1 + n + nonfail), "R3 scan shift cycles", scan_cnt, F * (1 + n + nonfail));
    endtask

    task automatic test_reset();
        check(!busy && !done && !res_valid && !cut_rst && !cut_en && !scan_en && !rec_rd,
              "R1 reset outputs", int'({busy, done, res_valid, cut_rst, cut_en, scan_en, rec_rd}), 0);
    endtask

    task automatic test_mixed();
        set_rec(0, 2,  16'h0200);  // high bit reaches outputs
        set_rec(1, 0,  16'h0008);  // low bit dies at reload
        set_rec(2, 18, 16'h0008);  // too late to die
        set_rec(3, 5,  16'h0402);  // two bits
        set_rec(4, 3,  16'h0041);  // two low bits
        set_rec(5, C,  16'h0010);  // start at end
        set_rec(6, 25, 16'h0000);  // beyond end, clean
        set_rec(7, 19, 16'h0100);  // last cycle, hidden bit
        set_rec(8, 7,  16'h0000);  // no flip
        run_campaign(9, "mixed");
    endtask

    task automatic test_zero();
        run_campaign(0, "empty");
    endtask

    task automatic test_restart();
        set_rec(0, 10, 16'h8000);
        set_rec(1, 0,  16'h0800);
        set_rec(2, 12, 16'h00F0);
        run_campaign(3, "restart");
    endtask

    initial begin
        gs[0] = '0;
        for (int k = 0; k < C; k++) begin
            gs[k+1] = step_state(gs[k], k);
            exp_mem[k] = outs(gs[k+1]);
        end
        for (int i = 0; i < NREC; i++) rec_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_mixed();
        test_zero();
        test_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule